// File: doc/BRIEF.md
# Three-Level Nested Interrupt Controller

This block sits between a set of interrupt request lines and a CPU core. It groups the requests into ten vector slots. Each slot has an enable bit and a one-bit level choice. Slots 0 and 1 choose between low and the topmost level. Every other slot chooses between low and high. In every cycle the block finds the best pending, enabled slot. The winner is the slot with the highest level, and a tie goes to the slot with the smaller index. The block then raises a pending flag when that winner outranks the handler that is already running.

When the CPU acknowledges while the flag is up, the block registers an accept strobe and a vector address one cycle later. At that same edge it pushes the winner's level onto a small level stack. An end-of-handler strobe pops the stack and brings back the level that was active before. A request at or below the running level is held back until the level drops. Several sources may be ORed onto one request line, because the block sees only slots. The per-source flags and the CPU itself are not part of this block.

Top module: `nest_irq_ctrl`

## Requirements
- R1: The vector address presented with an accept strobe equals 3 + 8 × slot index, so it runs from 0x00003 for slot 0 to 0x0004B for slot 9.
- R2: `lvl_sel[s]` = 0 gives slot s the low level (code 1). `lvl_sel[s]` = 1 gives the top level (code 3) for slots 0 and 1 and the high level (code 2) for slots 2 to 9. `cur_lvl` reports the running level with 0 meaning no handler active.
- R3: Among the pending, enabled slots, the slot with the highest level wins.
- R4: Among winners of equal level, the slot with the lowest index is taken.
- R5: `irq_pending` is high only when the winner's level is strictly above `cur_lvl`. An acknowledge while `irq_pending` is low has no effect.
- R6: A slot whose `slot_en` bit is 0 never wins. While `glob_en` is 0, nothing is pending and nothing is accepted.
- R7: Take an edge at which `cpu_ack` and `irq_pending` are both high and `eoh` is low. After that edge, `take` is high for that one cycle with the winner's vector, and `cur_lvl` becomes the winner's level.
- R8: `eoh` pops the level stack and restores the previous `cur_lvl`. `eoh` with an empty stack changes nothing.
- R9: When `eoh` and `cpu_ack` are high in the same cycle, the pop is performed and the acknowledge is ignored.
- R10: After reset, `take` is 0, `cur_lvl` is 0 and `depth` is 0.
- R11: Handlers nest up to three deep, and `depth` reports the number of active handlers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 10 | Pending request per vector slot |
| slot_en | input | 10 | Enable per vector slot |
| lvl_sel | input | 10 | Level choice per slot (0 low, 1 elevated) |
| glob_en | input | 1 | Master enable for acceptance |
| cpu_ack | input | 1 | CPU ready to take an interrupt |
| eoh | input | 1 | End of the running handler |
| irq_pending | output | 1 | A request may preempt the current level |
| take | output | 1 | Registered accept strobe |
| vec_addr | output | 20 | Vector address of the accepted slot |
| cur_lvl | output | 2 | Level currently serviced (0 none) |
| depth | output | 2 | Number of nested active handlers |

## Verification
Two sweeps walk every one of the 1024 request masks. Each sweep uses a fixed mix of level choices and slot enables, and the stack is empty each time. This tells apart level-first arbitration from index-first arbitration, and it exposes any disabled slot that leaks into the result. A third sweep walks all 1024 level-choice patterns. It takes a low-index-9 handler first and then offers all slots, which separates the top and high mappings and shows whether preemption happens only on a strict level increase. Directed sequences then cover:
- a three-deep nest with the pop order checked,
- a refused request at the same level,
- `eoh` and `cpu_ack` in the same cycle,
- `eoh` with an empty stack,
- `glob_en` held at 0.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
   typedef enum logic [1:0] {
      LVL_IDLE = 2'd0,
      LVL_LOW  = 2'd1,
      LVL_HIGH = 2'd2,
      LVL_TOP  = 2'd3
   } prio_t;
endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
   import irq_nest_pkg::*;
#(
   parameter int NUM_SLOTS = 10,
   parameter int TOP_SLOTS = 2,
   parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] req,
   input  logic [NUM_SLOTS-1:0] slot_en,
   input  logic [NUM_SLOTS-1:0] lvl_sel,
   output prio_t                win_lvl,
   output logic [IDX_W-1:0]     win_idx
);
   localparam logic [IDX_W-1:0] TOP_LIM = IDX_W'(TOP_SLOTS);

   prio_t slot_lvl [NUM_SLOTS];

   // per-slot effective level; the elevated choice depends on slot position
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      if (s < TOP_SLOTS) begin : g_top
         assign slot_lvl[s] = !(req[s] && slot_en[s]) ? LVL_IDLE :
                              (lvl_sel[s] ? LVL_TOP : LVL_LOW);
      end else begin : g_std
         assign slot_lvl[s] = !(req[s] && slot_en[s]) ? LVL_IDLE :
                              (lvl_sel[s] ? LVL_HIGH : LVL_LOW);
      end
   end

   // scan downward with >= so ties end on the smallest index
   always_comb begin
      win_lvl = LVL_IDLE;
      win_idx = '0;
      for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
         if (slot_lvl[s] >= win_lvl) begin
            win_lvl = slot_lvl[s];
            win_idx = IDX_W'(s);
         end
      end
   end

   p_top_only_low_slots_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (win_lvl == LVL_TOP) |-> (win_idx < TOP_LIM));

   p_winner_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_lvl != LVL_IDLE) |-> (req[win_idx] && slot_en[win_idx]));
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
   import irq_nest_pkg::*;
#(
   parameter int DEPTH = 3,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  prio_t            push_lvl,
   input  logic             pop,
   output prio_t            cur_lvl,
   output logic [CNT_W-1:0] depth
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   prio_t slot_q [DEPTH];
   logic  do_pop;

   assign do_pop  = pop && (depth != '0);
   assign cur_lvl = slot_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= LVL_IDLE;
         depth <= '0;
      end else if (do_pop) begin
         for (int i = 0; i < DEPTH - 1; i++) slot_q[i] <= slot_q[i+1];
         slot_q[DEPTH-1] <= LVL_IDLE;
         depth <= depth - CNT_W'(1);
      end else if (push) begin
         slot_q[0] <= push_lvl;
         for (int i = 1; i < DEPTH; i++) slot_q[i] <= slot_q[i-1];
         depth <= depth + CNT_W'(1);
      end
   end

   p_push_above_r5: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (push_lvl > cur_lvl));

   p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (depth < FULL));

   p_push_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (cur_lvl == $past(push_lvl)));

   p_pop_lowers_r8: assert property (@(posedge clk) disable iff (!rst_n)
      do_pop |=> (cur_lvl < $past(cur_lvl)));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import irq_nest_pkg::*;
#(
   parameter int NUM_SLOTS  = 10,
   parameter int TOP_SLOTS  = 2,
   parameter int ADDR_W     = 20,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STEP   = 8,
   parameter int NEST_DEPTH = 3,
   localparam int IDX_W     = $clog2(NUM_SLOTS),
   localparam int CNT_W     = $clog2(NEST_DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] req,
   input  logic [NUM_SLOTS-1:0] slot_en,
   input  logic [NUM_SLOTS-1:0] lvl_sel,
   input  logic                 glob_en,
   input  logic                 cpu_ack,
   input  logic                 eoh,
   output logic                 irq_pending,
   output logic                 take,
   output logic [ADDR_W-1:0]    vec_addr,
   output logic [1:0]           cur_lvl,
   output logic [CNT_W-1:0]     depth
);
   if (TOP_SLOTS > NUM_SLOTS) begin : g_bad_top
      $error("TOP_SLOTS exceeds NUM_SLOTS");
   end
   if (NEST_DEPTH < 3) begin : g_bad_depth
      $error("NEST_DEPTH must hold one entry per level");
   end
   if (VEC_BASE + VEC_STEP * (NUM_SLOTS - 1) >= (1 << ADDR_W)) begin : g_bad_addr
      $error("vector range does not fit ADDR_W");
   end

   prio_t            win_lvl;
   logic [IDX_W-1:0] win_idx;
   prio_t            run_lvl;
   logic             accept;

   irq_prio_arb #(
      .NUM_SLOTS (NUM_SLOTS),
      .TOP_SLOTS (TOP_SLOTS),
      .IDX_W     (IDX_W)
   ) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .slot_en (slot_en),
      .lvl_sel (lvl_sel),
      .win_lvl (win_lvl),
      .win_idx (win_idx)
   );

   assign irq_pending = glob_en && (win_lvl > run_lvl);
   assign accept      = cpu_ack && irq_pending && !eoh;

   irq_lvl_stack #(
      .DEPTH (NEST_DEPTH),
      .CNT_W (CNT_W)
   ) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (accept),
      .push_lvl (win_lvl),
      .pop      (eoh),
      .cur_lvl  (run_lvl),
      .depth    (depth)
   );

   assign cur_lvl = run_lvl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take     <= 1'b0;
         vec_addr <= '0;
      end else begin
         take <= accept;
         if (accept) vec_addr <= ADDR_W'(VEC_BASE + VEC_STEP * int'(win_idx));
      end
   end

   p_take_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ($past(cpu_ack) && !$past(eoh)));

   p_take_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (cur_lvl > $past(cur_lvl)));

   p_idle_no_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |=> !take);
endmodule

// File: tb/sim_nest_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nest_irq_ctrl;
   localparam int N = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [N-1:0] req = '0, slot_en = '0, lvl_sel = '0;
   logic glob_en = 1'b0, cpu_ack = 1'b0, eoh = 1'b0;
   logic irq_pending, take;
   logic [19:0] vec_addr;
   logic [1:0] cur_lvl, depth;

   int n_chk = 0, n_fail = 0;
   int mst [4];
   int mdep = 0;

   nest_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .slot_en(slot_en), .lvl_sel(lvl_sel),
      .glob_en(glob_en), .cpu_ack(cpu_ack), .eoh(eoh), .irq_pending(irq_pending),
      .take(take), .vec_addr(vec_addr), .cur_lvl(cur_lvl), .depth(depth)
   );

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int slot_lv(int s);
      if (!lvl_sel[s]) return 1;
      return (s < 2) ? 3 : 2;
   endfunction

   function automatic int mcur();
      return (mdep == 0) ? 0 : mst[mdep-1];
   endfunction

   task automatic arb(output int w, output int wl);
      w = -1; wl = 0;
      for (int s = 0; s < N; s++)
         if (req[s] && slot_en[s] && slot_lv(s) > wl) begin
            w = s; wl = slot_lv(s);
         end
   endtask

   task automatic step(input bit a, input bit e);
      int w, wl;
      bit pend, tk;
      @(negedge clk);
      cpu_ack = a; eoh = e;
      #1;
      arb(w, wl);
      pend = glob_en && (wl > mcur());
      chk("R5", "pending", int'(irq_pending), int'(pend));
      @(posedge clk);
      #1;
      cpu_ack = 1'b0; eoh = 1'b0;
      tk = a && pend && !e;
      if (e && mdep > 0) mdep--;
      else if (tk) begin mst[mdep] = wl; mdep++; end
      chk("R7", "take", int'(take), int'(tk));
      if (tk) begin
         chk("R1", "vector", int'(vec_addr), 3 + 8 * w);
         chk("R3", "winner level", int'(cur_lvl), wl);
      end
      chk("R11", "depth", int'(depth), mdep);
      chk("R8", "current level", int'(cur_lvl), mcur());
   endtask

   task automatic drain();
      while (mdep > 0) step(1'b0, 1'b1);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      // R10: reset state, even with requests and acknowledge active
      req = '1; slot_en = '1; glob_en = 1'b1; cpu_ack = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10", "take in reset", int'(take), 0);
      chk("R10", "level in reset", int'(cur_lvl), 0);
      chk("R10", "depth in reset", int'(depth), 0);
      cpu_ack = 1'b0; req = '0;
      rst_n = 1'b1;

      // sweep A: all masks, all enabled
      lvl_sel = 10'b10_0110_1001;
      for (int m = 0; m < 1024; m++) begin
         req = m[N-1:0];
         step(1'b1, 1'b0);
         drain();
      end

      // sweep B: partial enables, other level mix
      slot_en = 10'b11_0110_1110;
      lvl_sel = 10'b01_1001_1010;
      for (int m = 0; m < 1024; m++) begin
         req = m[N-1:0];
         step(1'b1, 1'b0);
         drain();
      end

      // sweep C: every level pattern, nest over a slot-9 handler
      slot_en = '1;
      for (int m = 0; m < 1024; m++) begin
         lvl_sel = m[N-1:0];
         req = 10'h200;
         step(1'b1, 1'b0);
         chk("R2", "slot 9 level", int'(cur_lvl), lvl_sel[9] ? 2 : 1);
         req = '1;
         step(1'b1, 1'b0);
         step(1'b1, 1'b0);
         drain();
      end

      // R4: equal low levels, lowest index wins
      lvl_sel = '0; req = 10'b00_0010_1000;
      step(1'b1, 1'b0);
      chk("R4", "tie vector", int'(vec_addr), 27);
      drain();

      // R5: same-level request refused while running
      req = 10'h010;
      step(1'b1, 1'b0);
      req = 10'h002;
      step(1'b1, 1'b0);
      chk("R5", "same level ack ignored", int'(depth), 1);
      drain();

      // R11 and R2: three-deep nest, then pops restore each level
      lvl_sel = 10'b01_1111_1111;
      req = 10'h200; step(1'b1, 1'b0);
      chk("R2", "low level", int'(cur_lvl), 1);
      req = 10'h020; step(1'b1, 1'b0);
      chk("R2", "high level", int'(cur_lvl), 2);
      req = 10'h001; step(1'b1, 1'b0);
      chk("R2", "top level", int'(cur_lvl), 3);
      chk("R11", "three deep", int'(depth), 3);
      req = 10'h002; step(1'b1, 1'b0);
      chk("R11", "top refused", int'(depth), 3);
      req = '0;
      step(1'b0, 1'b1); chk("R8", "pop to high", int'(cur_lvl), 2);
      step(1'b0, 1'b1); chk("R8", "pop to low", int'(cur_lvl), 1);
      step(1'b0, 1'b1); chk("R8", "pop to none", int'(cur_lvl), 0);
      step(1'b0, 1'b1); chk("R8", "pop when empty", int'(depth), 0);

      // R9: eoh and ack together
      lvl_sel = '0; req = 10'h200; step(1'b1, 1'b0);
      lvl_sel = 10'h001; req = 10'h001;
      step(1'b1, 1'b1);
      chk("R9", "ack dropped", int'(take), 0);
      chk("R9", "pop done", int'(depth), 0);

      // R6: gating
      glob_en = 1'b0; req = '1; lvl_sel = '1;
      step(1'b1, 1'b0);
      chk("R6", "global off", int'(take), 0);
      glob_en = 1'b1; slot_en = '0;
      step(1'b1, 1'b0);
      chk("R6", "all slots off", int'(take), 0);
      slot_en = 10'h080; lvl_sel = '0;
      step(1'b1, 1'b0);
      chk("R6", "only slot 7", int'(vec_addr), 59);
      drain();

      summary();
      $finish;
   end
endmodule